// File: doc/BRIEF.md
# Serial Calendar Clock

This block keeps a running calendar: seconds, minutes and hours in two-digit BCD, day of month in BCD, weekday from 0 to 6, and month from 1 to 12. Time advances from a periodic enable input, `tick_i`, in place of a crystal. `TICK_HZ` ticks make one second.

A host reaches the block through one 40-bit frame register. The host raises `stb_i` to latch a 3-bit command from `cmd_i`. That command sets how the frame register behaves afterwards:
- it holds its value,
- it shifts serial data from `din_i` toward `dout_o` on each rising edge of `sclk_i`,
- it loads its contents into the calendar,
- it captures the calendar,
- or, for three of the codes, it selects the rate of the square wave on `tp_o`.

`cs_i` gates both the strobe and the serial clock. `oe_i` releases `dout_o`.

The frame layout, from bit 39 down to bit 0, is:

| Bits | Field | Range |
|------|-------|-------|
| 39:36 | month | 1–12, binary |
| 35:32 | weekday | 0–6 |
| 31:24 | day | BCD |
| 23:16 | hour | BCD |
| 15:8 | minute | BCD |
| 7:0 | second | BCD |

`stb_i` and `sclk_i` are sampled on `clk_i`. The block acts on their rising edges.

Top module: `cal_clock_serial`

## Requirements
- R1: After reset, the calendar reads month 1, weekday 0, day 01, 00:00:00 (frame 40'h1001000000). The frame register is zero, the latched command is hold (000), the pulse rate is the low rate, and `tp_o` is 0.
- R2: A rising edge of `stb_i` while `cs_i` is high latches `cmd_i`. The latched command stays in force when `cmd_i` later changes without a strobe.
- R3: In shift mode (001), each rising edge of `sclk_i` moves the frame one place toward bit 0. `din_i` enters bit 39, and `dout_o` shows bit 0, so the frame leaves least-significant bit first.
- R4: A strobe of command 010 copies the frame register into the calendar and restarts the one-second prescaler.
- R5: A strobe of command 110 copies the calendar into the frame register.
- R6: The seconds field advances once every `TICK_HZ` ticks. Seconds carry after 59, minutes carry after 59, and hours wrap from 23 to 00, with BCD digit carries.
- R7: When hours wrap, the weekday steps and wraps from 6 to 0. The day steps through BCD and returns to 01 after the month's last day: 28 for February (no leap years), 30 for April, June, September and November, and 31 otherwise. The month then steps and wraps from 12 to 1.
- R8: In hold mode (000 or 111), `sclk_i` leaves the frame register unchanged, while the calendar keeps counting.
- R9: While `cs_i` is low, `stb_i` and `sclk_i` have no effect.
- R10: With `oe_i` low, `dout_o` is released to high impedance, so a pull-up on the line reads 1. With `oe_i` high, it drives bit 0 of the frame.
- R11: Commands 011, 100 and 101 set the `tp_o` square wave to 64 Hz, 256 Hz and 2048 Hz of tick time, and restart its divider. At `TICK_HZ`=4096, `tp_o` toggles every 32, 8 and 1 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase enable, `TICK_HZ` per second |
| cs_i | input | 1 | Chip select for strobe and serial clock |
| stb_i | input | 1 | Command strobe, acts on its rising edge |
| cmd_i | input | 3 | Command code |
| sclk_i | input | 1 | Serial shift clock, acts on its rising edge |
| din_i | input | 1 | Serial data in, enters frame bit 39 |
| oe_i | input | 1 | Output enable for `dout_o` |
| dout_o | output | 1 | Serial data out (frame bit 0), tri-state |
| tp_o | output | 1 | Timing-pulse square wave |

## Verification
The bench drives every input on the falling edge of `clk_i`. A strobe or serial-clock rise acts on the next rising edge, and its result is visible one clock after the input was raised. The bench samples `dout_o` on the falling edge that follows, before it pulses the next serial clock.

A second completes on exactly the `TICK_HZ`-th tick after a time set. The bench therefore applies whole multiples of `TICK_HZ` ticks before it reads the calendar back. Pulse rates are measured by counting `tp_o` transitions over a fixed number of ticks, sampled on falling edges.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic [2:0] {
    CMD_HOLD   = 3'b000,
    CMD_SHIFT  = 3'b001,
    CMD_SET    = 3'b010,
    CMD_TP_LO  = 3'b011,
    CMD_TP_MID = 3'b100,
    CMD_TP_HI  = 3'b101,
    CMD_READ   = 3'b110,
    CMD_HOLD_B = 3'b111
  } cmd_e;

  typedef enum logic [1:0] {
    RATE_LO  = 2'd0,
    RATE_MID = 2'd1,
    RATE_HI  = 2'd2
  } rate_e;

  typedef struct packed {
    logic [3:0] month;
    logic [3:0] wday;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } cal_time_t;

  localparam cal_time_t TIME_RST = '{month: 4'd1, wday: 4'd0, day: 8'h01,
                                     hour: 8'h00, min: 8'h00, sec: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] month_last_day(input logic [3:0] m);
    case (m)
      4'd2:                     return 8'h28;
      4'd4, 4'd6, 4'd9, 4'd11:  return 8'h30;
      default:                  return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler
  import cal_pkg::*;
#(
  parameter int TICK_HZ     = 4096,
  parameter int RATE_LO_HZ  = 64,
  parameter int RATE_MID_HZ = 256,
  parameter int RATE_HI_HZ  = 2048
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  sec_clr_i,
  input  logic  rate_ld_i,
  input  rate_e rate_i,
  output logic  sec_pulse_o,
  output logic  tp_o
);
  localparam int SEC_W   = (TICK_HZ > 1) ? $clog2(TICK_HZ) : 1;
  localparam int HALF_LO  = TICK_HZ / (2 * RATE_LO_HZ);
  localparam int HALF_MID = TICK_HZ / (2 * RATE_MID_HZ);
  localparam int HALF_HI  = TICK_HZ / (2 * RATE_HI_HZ);
  localparam int TP_W    = $clog2(HALF_LO + 1);

  logic [SEC_W-1:0] sec_cnt_q, sec_cnt_d;
  logic [TP_W-1:0]  tp_cnt_q, tp_cnt_d, half_sel;
  rate_e            rate_q, rate_d;
  logic             tp_q, tp_d;
  logic             sec_wrap, tp_wrap;

  assign sec_wrap    = (sec_cnt_q == SEC_W'(TICK_HZ - 1));
  assign sec_pulse_o = tick_i && sec_wrap && !sec_clr_i;

  always_comb begin
    sec_cnt_d = sec_cnt_q;
    if (sec_clr_i)     sec_cnt_d = '0;
    else if (tick_i)   sec_cnt_d = sec_wrap ? '0 : sec_cnt_q + SEC_W'(1);
  end

  always_comb begin
    case (rate_q)
      RATE_MID: half_sel = TP_W'(HALF_MID);
      RATE_HI:  half_sel = TP_W'(HALF_HI);
      default:  half_sel = TP_W'(HALF_LO);
    endcase
  end

  assign tp_wrap = (tp_cnt_q == half_sel - TP_W'(1));

  always_comb begin
    rate_d   = rate_q;
    tp_cnt_d = tp_cnt_q;
    tp_d     = tp_q;
    if (rate_ld_i) begin
      rate_d   = rate_i;
      tp_cnt_d = '0;
    end else if (tick_i) begin
      if (tp_wrap) begin
        tp_cnt_d = '0;
        tp_d     = ~tp_q;
      end else begin
        tp_cnt_d = tp_cnt_q + TP_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_cnt_q <= '0;
      tp_cnt_q  <= '0;
      rate_q    <= RATE_LO;
      tp_q      <= 1'b0;
    end else begin
      sec_cnt_q <= sec_cnt_d;
      tp_cnt_q  <= tp_cnt_d;
      rate_q    <= rate_d;
      tp_q      <= tp_d;
    end
  end

  assign tp_o = tp_q;
endmodule

// File: rtl/cal_time_cnt.sv
module cal_time_cnt
  import cal_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      adv_i,
  input  logic      load_i,
  input  cal_time_t load_val_i,
  output cal_time_t time_o
);
  cal_time_t cur_q, nxt;

  always_comb begin
    nxt = cur_q;
    if (load_i) begin
      nxt = load_val_i;
    end else if (adv_i) begin
      if (cur_q.sec != 8'h59) begin
        nxt.sec = bcd_inc(cur_q.sec);
      end else begin
        nxt.sec = 8'h00;
        if (cur_q.min != 8'h59) begin
          nxt.min = bcd_inc(cur_q.min);
        end else begin
          nxt.min = 8'h00;
          if (cur_q.hour != 8'h23) begin
            nxt.hour = bcd_inc(cur_q.hour);
          end else begin
            nxt.hour = 8'h00;
            nxt.wday = (cur_q.wday >= 4'd6) ? 4'd0 : cur_q.wday + 4'd1;
            if (cur_q.day != month_last_day(cur_q.month)) begin
              nxt.day = bcd_inc(cur_q.day);
            end else begin
              nxt.day   = 8'h01;
              nxt.month = (cur_q.month >= 4'd12) ? 4'd1 : cur_q.month + 4'd1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= TIME_RST;
    else         cur_q <= nxt;
  end

  assign time_o = cur_q;
endmodule

// File: rtl/cal_frame_reg.sv
module cal_frame_reg #(
  parameter int W = 40
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic         ser_i,
  input  logic         cap_en_i,
  input  logic [W-1:0] cap_val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (cap_en_i)        q_d = cap_val_i;
    else if (shift_en_i) q_d = {ser_i, q_q[W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/cal_clock_serial.sv
module cal_clock_serial
  import cal_pkg::*;
#(
  parameter int TICK_HZ     = 4096,
  parameter int RATE_LO_HZ  = 64,
  parameter int RATE_MID_HZ = 256,
  parameter int RATE_HI_HZ  = 2048
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       cs_i,
  input  logic       stb_i,
  input  logic [2:0] cmd_i,
  input  logic       sclk_i,
  input  logic       din_i,
  input  logic       oe_i,
  output logic       dout_o,
  output logic       tp_o
);
  localparam int FRAME_W = $bits(cal_time_t);

  logic [1:0]         rst_sync_q;
  logic               rst_n_int;
  logic               stb_q, sclk_q;
  logic               stb_rise, sclk_rise;
  cmd_e               mode_q, mode_d;
  cmd_e               cmd_in;
  logic               set_ld, read_cap, rate_ld, shift_en, sec_pulse;
  rate_e              rate_sel;
  logic [FRAME_W-1:0] sr_q;
  cal_time_t          time_q;

  // Reset asserted at once, released on a clock edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      stb_q  <= 1'b0;
      sclk_q <= 1'b0;
      mode_q <= CMD_HOLD;
    end else begin
      stb_q  <= stb_i;
      sclk_q <= sclk_i;
      mode_q <= mode_d;
    end
  end

  assign cmd_in    = cmd_e'(cmd_i);
  assign stb_rise  = cs_i && stb_i && !stb_q;
  assign sclk_rise = cs_i && sclk_i && !sclk_q;
  assign mode_d    = stb_rise ? cmd_in : mode_q;

  assign set_ld   = stb_rise && (cmd_in == CMD_SET);
  assign read_cap = stb_rise && (cmd_in == CMD_READ);
  assign rate_ld  = stb_rise && (cmd_in inside {CMD_TP_LO, CMD_TP_MID, CMD_TP_HI});
  assign shift_en = sclk_rise && !stb_rise && (mode_q == CMD_SHIFT);

  always_comb begin
    case (cmd_in)
      CMD_TP_MID: rate_sel = RATE_MID;
      CMD_TP_HI:  rate_sel = RATE_HI;
      default:    rate_sel = RATE_LO;
    endcase
  end

  cal_prescaler #(
    .TICK_HZ(TICK_HZ), .RATE_LO_HZ(RATE_LO_HZ),
    .RATE_MID_HZ(RATE_MID_HZ), .RATE_HI_HZ(RATE_HI_HZ)
  ) u_presc (
    .clk_i(clk_i), .rst_ni(rst_n_int), .tick_i(tick_i),
    .sec_clr_i(set_ld), .rate_ld_i(rate_ld), .rate_i(rate_sel),
    .sec_pulse_o(sec_pulse), .tp_o(tp_o)
  );

  cal_time_cnt u_time (
    .clk_i(clk_i), .rst_ni(rst_n_int), .adv_i(sec_pulse),
    .load_i(set_ld), .load_val_i(cal_time_t'(sr_q)), .time_o(time_q)
  );

  cal_frame_reg #(.W(FRAME_W)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_n_int), .shift_en_i(shift_en),
    .ser_i(din_i), .cap_en_i(read_cap), .cap_val_i(FRAME_W'(time_q)),
    .q_o(sr_q)
  );

  assign dout_o = oe_i ? sr_q[0] : 1'bz;
endmodule

// File: rtl/cal_clock_serial_chk.sv
module cal_clock_serial_chk
  import cal_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_i,
  input logic       tick_i,
  input logic       din_i,
  input logic       tp_o,
  input logic       stb_rise,
  input logic       sclk_rise,
  input cmd_e       mode_q,
  input logic [39:0] sr_q,
  input logic       sec_pulse,
  input cal_time_t  time_q
);
  AST_SHIFT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == CMD_SHIFT && sclk_rise && !stb_rise) |=> (sr_q[39] == $past(din_i))); // R3

  AST_HOLD_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q == CMD_HOLD || mode_q == CMD_HOLD_B) && !stb_rise) |=> $stable(sr_q)); // R8

  AST_CS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> $stable(mode_q)); // R9

  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_pulse && time_q.sec == 8'h59 && !stb_rise) |=> (time_q.sec == 8'h00)); // R6

  AST_TP_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !stb_rise) |=> $stable(tp_o)); // R11
endmodule

bind cal_clock_serial cal_clock_serial_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .tick_i(tick_i),
  .din_i(din_i), .tp_o(tp_o), .stb_rise(stb_rise), .sclk_rise(sclk_rise),
  .mode_q(mode_q), .sr_q(sr_q), .sec_pulse(sec_pulse), .time_q(time_q)
);

// File: tb/tb_cal_clock_serial.sv
`timescale 1ns/1ps
module tb_cal_clock_serial;
  localparam int TICK_HZ = 4096;
  localparam int NVEC = 9;
  // {start frame, seconds to advance, expected frame}
  localparam logic [87:0] VEC [NVEC] = '{
    {40'h1315102030, 8'd1, 40'h1315102031},
    {40'h1315102009, 8'd1, 40'h1315102010},
    {40'h1315102059, 8'd1, 40'h1315102100},
    {40'h1315105959, 8'd1, 40'h1315110000},
    {40'h1315235959, 8'd1, 40'h1416000000},
    {40'h2628235959, 8'd1, 40'h3001000000},
    {40'hC431235959, 8'd1, 40'h1501000000},
    {40'h4230235959, 8'd1, 40'h5301000000},
    {40'h1031235958, 8'd2, 40'h2101000000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, cs = 1'b1, stb = 1'b0, sclk = 1'b0, din = 1'b0, oe = 1'b1;
  logic [2:0] cmd = 3'b000;
  wire  dout_w;
  logic tp;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;
  pullup (dout_w);

  cal_clock_serial dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cs_i(cs), .stb_i(stb),
    .cmd_i(cmd), .sclk_i(sclk), .din_i(din), .oe_i(oe),
    .dout_o(dout_w), .tp_o(tp)
  );

  task automatic chk(input string req, input logic [39:0] got, input logic [39:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic strobe(input logic [2:0] c);
    @(negedge clk); cmd = c; stb = 1'b1;
    @(negedge clk); stb = 1'b0; cmd = ~c;
  endtask

  task automatic sclk_pulse(input logic d);
    @(negedge clk); din = d; sclk = 1'b1;
    @(negedge clk); sclk = 1'b0;
  endtask

  task automatic shift_in(input logic [39:0] v);
    for (int i = 0; i < 40; i++) sclk_pulse(v[i]);
  endtask

  task automatic shift_out(output logic [39:0] v);
    for (int i = 0; i < 40; i++) begin
      v[i] = dout_w;
      sclk_pulse(1'b0);
    end
  endtask

  task automatic ticks(input int n, output int tog);
    logic prev;
    tog = 0;
    @(negedge clk); tick = 1'b1; prev = tp;
    repeat (n) begin
      @(negedge clk);
      if (tp !== prev) tog++;
      prev = tp;
    end
    tick = 1'b0;
  endtask

  task automatic read_time(output logic [39:0] v);
    strobe(3'b110);
    strobe(3'b001);
    shift_out(v);
  endtask

  task automatic set_time(input logic [39:0] v);
    strobe(3'b001);
    shift_in(v);
    strobe(3'b010);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [39:0] got;
    int tog;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 dout", {39'd0, dout_w}, 40'd0);
    chk("R1 tp", {39'd0, tp}, 40'd0);
    read_time(got);
    chk("R1 calendar", got, 40'h1001000000);
    ticks(256, tog);
    chk("R1 default rate", 40'(tog), 40'd8);

    // R4 R5 R6 R7 R3: vector table
    for (int k = 0; k < NVEC; k++) begin
      set_time(VEC[k][87:48]);
      ticks(int'(VEC[k][47:40]) * TICK_HZ, tog);
      read_time(got);
      chk("R6 R7 vector", got, VEC[k][39:0]);
    end

    // R3 R2: shift order, latch holds with other code on pins
    strobe(3'b001);
    shift_in(40'hA5C3_0F96_E1);
    shift_out(got);
    chk("R3 R2 shift loop", got, 40'hA5C30F96E1);

    // R10: release with oe low
    strobe(3'b001);
    shift_in(40'h0000000002);
    @(negedge clk); oe = 1'b0;
    @(negedge clk);
    chk("R10 released", {39'd0, dout_w}, 40'd1);
    oe = 1'b1;
    @(negedge clk);
    chk("R10 driven", {39'd0, dout_w}, 40'd0);

    // R8: hold mode ignores sclk
    strobe(3'b001);
    shift_in(40'h123456789A);
    strobe(3'b000);
    for (int i = 0; i < 5; i++) sclk_pulse(1'b1);
    strobe(3'b001);
    shift_out(got);
    chk("R8 frame held", got, 40'h123456789A);
    // R8: counters run in hold
    set_time(40'h1315102030);
    strobe(3'b111);
    ticks(TICK_HZ, tog);
    read_time(got);
    chk("R8 counting in hold", got, 40'h1315102031);

    // R9: cs low blocks strobe
    set_time(40'h5210081500);
    strobe(3'b001);
    shift_in(40'h9999999999);
    cs = 1'b0;
    strobe(3'b010);
    cs = 1'b1;
    read_time(got);
    chk("R9 strobe ignored", got, 40'h5210081500);
    // R9: cs low blocks sclk
    strobe(3'b001);
    shift_in(40'h0F0F0F0F0F);
    cs = 1'b0;
    for (int i = 0; i < 5; i++) sclk_pulse(1'b1);
    cs = 1'b1;
    shift_out(got);
    chk("R9 sclk ignored", got, 40'h0F0F0F0F0F);

    // R11: pulse rates
    strobe(3'b101);
    ticks(256, tog);
    chk("R11 2048Hz", 40'(tog), 40'd256);
    strobe(3'b100);
    ticks(256, tog);
    chk("R11 256Hz", 40'(tog), 40'd32);
    strobe(3'b011);
    ticks(256, tog);
    chk("R11 64Hz", 40'(tog), 40'd8);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule